// File: doc/BRIEF.md
# Power-Stage Bring-Up Sequencer

This block sits on the controller side of a three-phase inverter with a brake switch. It prepares the power stage before the modulator is given control. On a start request it first drives all three lower-side switch commands ON together, as a train of short pulses. These pulses charge the floating high-side supply capacitors. It then runs a fixed clearing pass that may remove a short-circuit fault latched during charging. That pass pulses the brake command, then the three lower commands, then the three upper commands. Each of these pulse groups is separated by a dead gap.

After the clearing pass the block samples the fault line once. If the fault line is clear, the block raises a release flag that lets the modulator drive the switches. If the fault line is still active, the block raises an error flag and keeps the release withheld until a fresh start request arrives. All seven command lines are active low, so a low level means the switch is ON. The fault input is active low as well. Pulse width, dead gap and the charging pulse count limits are parameters given in clock cycles. The pulse count itself is an input.

Top module: `startupSeq`

## Requirements
- R1: After reset all seven command lines are high (OFF), and both the release flag and the error flag are low, until a start request rising edge is seen.
- R2: A rising edge on the start request begins charging on the next clock. During charging, lowCmdN is 3'b000 for PULSE_CYC cycles and then 3'b111 for PULSE_CYC cycles, repeated. brkCmdN and upCmdN stay high throughout charging.
- R3: The number of charging pulses equals the pulse count input, which is captured at the start edge.
- R4: A captured pulse count below CNT_MIN is raised to CNT_MIN, and one above CNT_MAX is lowered to CNT_MAX.
- R5: After charging, exactly one pulse of PULSE_CYC cycles is issued to each group in this order: brake first, then all three lower lines together, then all three upper lines together. No two groups are ever ON in the same cycle.
- R6: Each clearing pulse is followed by DEAD_CYC cycles with all lines OFF. No phase ever has its upper and lower lines ON together. An upper line turns ON only after all lower lines have been OFF for at least DEAD_CYC cycles.
- R7: The fault input (low = fault) is sampled only at the end of the last dead gap. A fault that is active during charging or clearing does not change the sequence.
- R8: If the fault is clear at that sample, the release flag rises and stays high with all lines OFF. The error flag stays low.
- R9: If the fault is active at that sample, the error flag rises and the release flag stays low. All lines stay OFF. This state holds even after the fault clears, until a new start edge arrives.
- R10: A start edge while released or in error restarts the full sequence, and both flags drop on the next clock.
- R11: Start edges that arrive while a sequence is running are ignored. The pulse train and its count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Start request; its rising edge starts a sequence |
| faultN | input | 1 | Short-circuit fault indication from the power stage, low = fault |
| pulseCount | input | CNT_W | Requested number of charging pulses |
| brkCmdN | output | 1 | Brake switch command, low = ON |
| lowCmdN | output | 3 | Lower-side switch commands per phase, low = ON |
| upCmdN | output | 3 | Upper-side switch commands per phase, low = ON |
| pwmRelease | output | 1 | High when the modulator may take control |
| errFlag | output | 1 | High when the fault persisted after the clearing pass |

## Verification
The embedded assertions watch the command lines on every cycle. They check that no phase has both switches ON, that at most one group is ON, that the dead gap is kept before any upper pulse, that the two flags never coincide, and that a held release or error state does not decay without a start edge. The captured pulse count is also checked to stay within its clamp limits. Only the bench scenarios can show the whole shape of a run: the exact number and width of the charging pulses for several counts, including both clamp limits; the brake, lower, upper order; the outcome for a fault that clears mid-sequence versus one that persists; and that a start edge arriving mid-run is ignored.

// File: rtl/startupPkg.sv
package startupPkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CHG_ON,
    S_CHG_OFF,
    S_BRK_ON,
    S_GAP_BRK,
    S_LOW_ON,
    S_GAP_LOW,
    S_UP_ON,
    S_GAP_UP,
    S_RELEASED,
    S_FAILED
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tmrClear;
    logic cntLoad;
    logic cntInc;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic startEdge;
    logic pulseEnd;
    logic gapEnd;
    logic lastPulse;
    logic faultOn;
  } dpStatus_t;

endpackage

// File: rtl/startupTimer.sv
module startupTimer
  import startupPkg::*;
#(
  parameter int PULSE_CYC   = 5000,
  parameter int DEAD_CYC    = 1000,
  parameter int CNT_MIN     = 10,
  parameter int CNT_MAX     = 500,
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             faultN,
  input  logic [CNT_W-1:0] pulseCount,
  input  ctrlStrobe_t      strobe,
  output dpStatus_t        status
);

  localparam int TMR_MAX = (PULSE_CYC > DEAD_CYC) ? PULSE_CYC : DEAD_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_LO = CNT_W'(CNT_MIN);
  localparam logic [CNT_W-1:0] CNT_HI = CNT_W'(CNT_MAX);

  logic [TMR_W-1:0] tmrQ;
  logic [CNT_W-1:0] targetQ;
  logic [CNT_W-1:0] issuedQ;
  logic             startPrev;
  logic             faultSync;

  // start edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startPrev <= 1'b0;
    else       startPrev <= startReq;
  end

  // fault synchronizer, depth chosen by parameter
  generate
    if (SYNC_STAGES == 0) begin : gNoSync
      assign faultSync = faultN;
    end else begin : gSync
      logic [SYNC_STAGES-1:0] syncQ;
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : gStage
        if (g == 0) begin : gFirst
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN) syncQ[g] <= 1'b1;
            else       syncQ[g] <= faultN;
          end
        end else begin : gNext
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN) syncQ[g] <= 1'b1;
            else       syncQ[g] <= syncQ[g-1];
          end
        end
      end
      assign faultSync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  // shared interval timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           tmrQ <= '0;
    else if (strobe.tmrClear)            tmrQ <= '0;
    else if (tmrQ != TMR_W'(TMR_MAX))    tmrQ <= tmrQ + 1'b1;
  end

  function automatic logic [CNT_W-1:0] clampCount(input logic [CNT_W-1:0] req);
    if (req < CNT_LO)      return CNT_LO;
    else if (req > CNT_HI) return CNT_HI;
    else                   return req;
  endfunction

  // charging pulse counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetQ <= CNT_LO;
      issuedQ <= '0;
    end else if (strobe.cntLoad) begin
      targetQ <= clampCount(pulseCount);
      issuedQ <= '0;
    end else if (strobe.cntInc) begin
      issuedQ <= issuedQ + 1'b1;
    end
  end

  always_comb begin
    status.startEdge = startReq & ~startPrev;
    status.pulseEnd  = (tmrQ == TMR_W'(PULSE_CYC - 1));
    status.gapEnd    = (tmrQ == TMR_W'(DEAD_CYC - 1));
    status.lastPulse = (issuedQ == targetQ - 1'b1);
    status.faultOn   = ~faultSync;
  end

  a_r4_target_range: assert property (@(posedge clk) disable iff (!rstN)
    (targetQ >= CNT_LO) && (targetQ <= CNT_HI));

  a_r3_issued_below_target: assert property (@(posedge clk) disable iff (!rstN)
    issuedQ < targetQ);

endmodule

// File: rtl/startupCtrl.sv
module startupCtrl
  import startupPkg::*;
#(
  parameter int DEAD_CYC = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        brkCmdN,
  output logic [2:0]  lowCmdN,
  output logic [2:0]  upCmdN,
  output logic        pwmRelease,
  output logic        errFlag
);

  seqState_t stQ, stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stQ <= S_IDLE;
    else       stQ <= stNext;
  end

  always_comb begin
    stNext = stQ;
    strobe = '0;
    unique case (stQ)
      S_IDLE, S_RELEASED, S_FAILED: begin
        if (status.startEdge) begin
          stNext          = S_CHG_ON;
          strobe.tmrClear = 1'b1;
          strobe.cntLoad  = 1'b1;
        end
      end
      S_CHG_ON: begin
        if (status.pulseEnd) begin
          stNext          = S_CHG_OFF;
          strobe.tmrClear = 1'b1;
        end
      end
      S_CHG_OFF: begin
        if (status.pulseEnd) begin
          strobe.tmrClear = 1'b1;
          if (status.lastPulse) begin
            stNext = S_BRK_ON;
          end else begin
            stNext        = S_CHG_ON;
            strobe.cntInc = 1'b1;
          end
        end
      end
      S_BRK_ON: begin
        if (status.pulseEnd) begin
          stNext          = S_GAP_BRK;
          strobe.tmrClear = 1'b1;
        end
      end
      S_GAP_BRK: begin
        if (status.gapEnd) begin
          stNext          = S_LOW_ON;
          strobe.tmrClear = 1'b1;
        end
      end
      S_LOW_ON: begin
        if (status.pulseEnd) begin
          stNext          = S_GAP_LOW;
          strobe.tmrClear = 1'b1;
        end
      end
      S_GAP_LOW: begin
        if (status.gapEnd) begin
          stNext          = S_UP_ON;
          strobe.tmrClear = 1'b1;
        end
      end
      S_UP_ON: begin
        if (status.pulseEnd) begin
          stNext          = S_GAP_UP;
          strobe.tmrClear = 1'b1;
        end
      end
      S_GAP_UP: begin
        if (status.gapEnd) begin
          stNext          = status.faultOn ? S_FAILED : S_RELEASED;
          strobe.tmrClear = 1'b1;
        end
      end
      default: begin
        stNext          = S_IDLE;
        strobe.tmrClear = 1'b1;
      end
    endcase
  end

  // command decode from the state register
  always_comb begin
    lowCmdN    = (stQ == S_CHG_ON || stQ == S_LOW_ON) ? 3'b000 : 3'b111;
    upCmdN     = (stQ == S_UP_ON) ? 3'b000 : 3'b111;
    brkCmdN    = (stQ != S_BRK_ON);
    pwmRelease = (stQ == S_RELEASED);
    errFlag    = (stQ == S_FAILED);
  end

  // cycles since any lower line was ON, saturating at DEAD_CYC
  localparam int GAP_W = $clog2(DEAD_CYC + 1);
  logic [GAP_W-1:0] sinceLowQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               sinceLowQ <= GAP_W'(DEAD_CYC);
    else if (lowCmdN != 3'b111)              sinceLowQ <= '0;
    else if (sinceLowQ != GAP_W'(DEAD_CYC))  sinceLowQ <= sinceLowQ + 1'b1;
  end

  a_r6_dead_gap: assert property (@(posedge clk) disable iff (!rstN)
    (upCmdN != 3'b111) |-> (sinceLowQ >= GAP_W'(DEAD_CYC)));

  a_r6_no_shoot_through: assert property (@(posedge clk) disable iff (!rstN)
    (~upCmdN & ~lowCmdN) == 3'b000);

  a_r5_one_group: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~brkCmdN, lowCmdN != 3'b111, upCmdN != 3'b111}));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(pwmRelease && errFlag));

  a_r8_release_holds: assert property (@(posedge clk) disable iff (!rstN)
    (pwmRelease && !status.startEdge) |=> pwmRelease);

  a_r9_error_holds: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !status.startEdge) |=> errFlag);

  a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    ((pwmRelease || errFlag) && status.startEdge) |=> (!pwmRelease && !errFlag && lowCmdN == 3'b000));

endmodule

// File: rtl/startupSeq.sv
module startupSeq
  import startupPkg::*;
#(
  parameter int PULSE_CYC   = 5000,
  parameter int DEAD_CYC    = 1000,
  parameter int CNT_MIN     = 10,
  parameter int CNT_MAX     = 500,
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             faultN,
  input  logic [CNT_W-1:0] pulseCount,
  output logic             brkCmdN,
  output logic [2:0]       lowCmdN,
  output logic [2:0]       upCmdN,
  output logic             pwmRelease,
  output logic             errFlag
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  startupTimer #(
    .PULSE_CYC  (PULSE_CYC),
    .DEAD_CYC   (DEAD_CYC),
    .CNT_MIN    (CNT_MIN),
    .CNT_MAX    (CNT_MAX),
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uTimer (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .faultN    (faultN),
    .pulseCount(pulseCount),
    .strobe    (strobe),
    .status    (status)
  );

  startupCtrl #(
    .DEAD_CYC(DEAD_CYC)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .status    (status),
    .strobe    (strobe),
    .brkCmdN   (brkCmdN),
    .lowCmdN   (lowCmdN),
    .upCmdN    (upCmdN),
    .pwmRelease(pwmRelease),
    .errFlag   (errFlag)
  );

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (brkCmdN && lowCmdN == 3'b111 && upCmdN == 3'b111 && !pwmRelease && !errFlag));

endmodule

// File: tb/startupSeq_test.sv
module startupSeq_test;

  localparam int P  = 6;
  localparam int D  = 3;
  localparam int CW = 10;

  localparam logic [6:0] PAT_OFF = 7'b1111111;
  localparam logic [6:0] PAT_LOW = 7'b1111000;
  localparam logic [6:0] PAT_BRK = 7'b0111111;
  localparam logic [6:0] PAT_UP  = 7'b1000111;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic          faultN = 1'b1;
  logic [CW-1:0] pulseCount = '0;
  logic          brkCmdN;
  logic [2:0]    lowCmdN;
  logic [2:0]    upCmdN;
  logic          pwmRelease;
  logic          errFlag;

  int checks = 0;
  int errors = 0;

  logic [6:0] segPat [0:1199];
  int         segLen [0:1199];
  int         nSeg;
  bit         firstFlagsClear;

  startupSeq #(
    .PULSE_CYC(P), .DEAD_CYC(D), .CNT_MIN(10), .CNT_MAX(500),
    .CNT_W(CW), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .faultN(faultN),
    .pulseCount(pulseCount), .brkCmdN(brkCmdN), .lowCmdN(lowCmdN),
    .upCmdN(upCmdN), .pwmRelease(pwmRelease), .errFlag(errFlag)
  );

  always #2 clk = ~clk;

  function automatic logic [6:0] linesNow();
    return {brkCmdN, upCmdN, lowCmdN};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  // start a sequence and record the line pattern segments until a flag rises
  task automatic captureRun(input int cnt);
    logic [6:0] pat;
    int guard;
    pulseCount = CW'(cnt);
    @(negedge clk);
    startReq = 1'b1;
    nSeg = 0;
    guard = 0;
    @(negedge clk);
    startReq = 1'b0;
    firstFlagsClear = !pwmRelease && !errFlag;
    while (!(pwmRelease || errFlag) && guard < 30000) begin
      pat = linesNow();
      if (nSeg > 0 && segPat[nSeg-1] == pat) begin
        segLen[nSeg-1]++;
      end else if (nSeg < 1200) begin
        segPat[nSeg] = pat;
        segLen[nSeg] = 1;
        nSeg++;
      end
      guard++;
      @(negedge clk);
    end
  endtask

  // compare the recorded run against the required shape
  task automatic checkRun(input int expN, input bit expErr, input string cntReq);
    int chg = 0;
    int base;
    bit chgOk = 1'b1;
    for (int i = 0; i < nSeg && segPat[i] != PAT_BRK; i++)
      if (segPat[i] == PAT_LOW) chg++;
    check(chg == expN, cntReq, "charging pulse count", chg, expN);
    check(nSeg == 2*expN + 6, cntReq, "segment count", nSeg, 2*expN + 6);
    check(firstFlagsClear, "R10", "flags low after start edge", 0, 0);
    if (nSeg == 2*expN + 6) begin
      for (int i = 0; i < 2*expN; i++) begin
        if (segLen[i] != P) chgOk = 1'b0;
        if (segPat[i] != ((i % 2 == 0) ? PAT_LOW : PAT_OFF)) chgOk = 1'b0;
      end
      check(chgOk, "R2", "charging pulse shape", chgOk, 1);
      base = 2*expN;
      check(segPat[base] == PAT_BRK && segLen[base] == P, "R5", "brake pulse",
            segLen[base], P);
      check(segPat[base+2] == PAT_LOW && segLen[base+2] == P, "R5", "lower pulse",
            segLen[base+2], P);
      check(segPat[base+4] == PAT_UP && segLen[base+4] == P, "R5", "upper pulse",
            segLen[base+4], P);
      check(segPat[base+1] == PAT_OFF && segLen[base+1] == D, "R6", "gap after brake",
            segLen[base+1], D);
      check(segPat[base+3] == PAT_OFF && segLen[base+3] == D, "R6", "gap after lower",
            segLen[base+3], D);
      check(segPat[base+5] == PAT_OFF && segLen[base+5] == D, "R6", "gap after upper",
            segLen[base+5], D);
    end
    if (expErr) begin
      check(errFlag && !pwmRelease, "R9", "error flag set", errFlag, 1);
    end else begin
      check(pwmRelease && !errFlag, "R8", "release flag set", pwmRelease, 1);
    end
    check(linesNow() == PAT_OFF, expErr ? "R9" : "R8", "lines off at end",
          linesNow(), PAT_OFF);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(linesNow() == PAT_OFF, "R1", "lines off in reset", linesNow(), PAT_OFF);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check(linesNow() == PAT_OFF, "R1", "lines off before start", linesNow(), PAT_OFF);
    check(!pwmRelease, "R1", "release low before start", pwmRelease, 0);
    check(!errFlag, "R1", "error low before start", errFlag, 0);
  endtask

  task automatic testNominal();
    captureRun(12);
    checkRun(12, 1'b0, "R3");
    repeat (20) @(negedge clk);
    check(pwmRelease && linesNow() == PAT_OFF, "R8", "release held", pwmRelease, 1);
  endtask

  task automatic testClamp();
    captureRun(3);
    checkRun(10, 1'b0, "R4");
    captureRun(600);
    checkRun(500, 1'b0, "R4");
  endtask

  task automatic testFaultClears();
    faultN = 1'b0;
    fork
      begin
        repeat (2*11*P + P/2 + 2) @(negedge clk);
        faultN = 1'b1;
      end
    join_none
    captureRun(11);
    checkRun(11, 1'b0, "R7");
  endtask

  task automatic testFaultStuck();
    faultN = 1'b0;
    captureRun(10);
    checkRun(10, 1'b1, "R9");
    repeat (30) @(negedge clk);
    check(errFlag && !pwmRelease && linesNow() == PAT_OFF, "R9", "error held",
          errFlag, 1);
    faultN = 1'b1;
    repeat (10) @(negedge clk);
    check(errFlag && linesNow() == PAT_OFF, "R9", "error held after fault clears",
          errFlag, 1);
    captureRun(10);
    checkRun(10, 1'b0, "R10");
  endtask

  task automatic testStartIgnored();
    fork
      begin
        repeat (15) @(negedge clk);
        startReq = 1'b1;
        repeat (2) @(negedge clk);
        startReq = 1'b0;
        repeat (70) @(negedge clk);
        startReq = 1'b1;
        @(negedge clk);
        startReq = 1'b0;
      end
    join_none
    captureRun(13);
    checkRun(13, 1'b0, "R11");
  endtask

  initial begin
    testReset();
    testNominal();
    testClamp();
    testFaultClears();
    testFaultStuck();
    testStartIgnored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule